// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. It takes three lines: a bit clock, a frame (word-select) clock and a data line. All three are treated as asynchronous to the fabric clock. Each line passes through a synchronizer. The receiver then acts on every rising edge of the bit clock that it detects. Because of this, a bit clock that stops, bursts or stretches changes nothing in the captured words.

A two-bit format input picks one of four framings: I2S, left-justified, right-justified, or a DSP slot mode with a short frame pulse. A two-bit width input picks 24, 20 or 16 bits per channel. Every word leaves the block as a 24-bit left-aligned two's-complement value, with zeros below the received LSB. A one-cycle strobe marks each stereo pair.

After the synchronous reset is released, the receiver stays idle until the first rising frame-clock edge. It then reports only complete left-then-right pairs. Format and width are expected to stay constant while the block is out of reset.

Top module: `ar_rx`

## Requirements
- R1: While `rst` is high, `valid_o` is low and both sample outputs are zero. After release, nothing is captured before the first rising frame-clock edge, and a right word with no left word captured before it in the same frame is dropped.
- R2: With `fmt_i` = 0 (I2S), frame clock low marks the left channel. The MSB is sampled on the second bit-clock rise after a frame-clock transition, and the bit on the first rise is ignored.
- R3: With `fmt_i` = 1 (left-justified), frame clock high marks the left channel. The MSB is sampled on the first bit-clock rise after the transition.
- R4: With `fmt_i` = 2 (right-justified), frame clock high marks the left channel. The word is the last N bits sampled before the frame-clock transition, and any earlier bits in that half are discarded.
- R5: With `fmt_i` = 3 (DSP), each rising frame-clock edge opens a slot and the MSB follows on the next bit-clock rise. Slots alternate left then right, and the first slot after reset is left.
- R6: `wsel_i` = 0 selects 24 bits, 1 selects 20 bits, and 2 or 3 select 16 bits. The output places the received MSB at bit 23 and zero-fills the bits below the LSB.
- R7: `valid_o` is high for exactly one clock per stereo frame, in the cycle the new pair appears. Between strobes the sample outputs hold their values.
- R8: Bit-clock stretches of any length between edges leave the captured values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; must be several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| lrck_i | input | 1 | Frame / word-select clock, asynchronous |
| sdata_i | input | 1 | Serial audio data, MSB first |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| wsel_i | input | 2 | Word width: 0 = 24, 1 = 20, 2/3 = 16 bits |
| left_o | output | 24 | Left sample, left-aligned two's complement |
| right_o | output | 24 | Right sample, left-aligned two's complement |
| valid_o | output | 1 | One-cycle strobe per new stereo pair |

## Verification
Each framing is driven with streams where every bit slot outside the word carries ones. Any off-by-one in the MSB position, or any leak of a leading bit in right-justified mode, therefore corrupts the result visibly. The sample sets include the most negative value and all-ones words, so a sign error or a misplaced zero pad shows up at once at each width. Two runs insert uneven stretches into the bit clock; they show whether capture follows bit-clock edges rather than fabric-clock time. I2S runs that start in the left half show that the partial frame before the first rising edge is discarded.

// File: rtl/ar_pkg.sv
package ar_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  // Number of data bits per channel for a width code.
  function automatic logic [4:0] word_bits(input logic [1:0] wsel);
    case (wsel)
      2'd0:    return 5'd24;
      2'd1:    return 5'd20;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/ar_sync.sv
module ar_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/ar_framer.sv
module ar_framer
  import ar_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_rise_i,
  input  logic       lr_i,
  input  fmt_e       fmt_i,
  input  logic [4:0] nbits_i,
  output logic       done_o,
  output logic       left_o,
  output logic       take_prev_o
);

  logic             lr_prev, armed, dsp_slot;
  logic [CNT_W-1:0] cnt, cnt_inc, cnt_nxt, n_ext;
  logic             edge_w, rise_w, restart, active, hit;

  always_comb begin
    edge_w  = lr_i ^ lr_prev;
    rise_w  = lr_i & ~lr_prev;
    restart = (fmt_i == FMT_DSP) ? rise_w : edge_w;
    cnt_inc = (cnt == {CNT_W{1'b1}}) ? cnt : cnt + 1'b1;
    cnt_nxt = restart ? '0 : cnt_inc;
    n_ext   = CNT_W'(nbits_i);
    active  = armed | rise_w;
    hit         = 1'b0;
    left_o      = 1'b0;
    take_prev_o = 1'b0;
    case (fmt_i)
      FMT_I2S: begin
        hit    = (cnt_nxt == n_ext);
        left_o = ~lr_i;
      end
      FMT_LJ: begin
        hit    = (cnt_nxt == n_ext - 1'b1);
        left_o = lr_i;
      end
      FMT_RJ: begin
        hit         = armed & edge_w;
        left_o      = lr_prev;
        take_prev_o = 1'b1;
      end
      default: begin
        hit    = (cnt_nxt == n_ext);
        left_o = ~dsp_slot;
      end
    endcase
    done_o = bit_rise_i & active & hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev  <= 1'b0;
      armed    <= 1'b0;
      dsp_slot <= 1'b0;
      cnt      <= '0;
    end else if (bit_rise_i) begin
      lr_prev <= lr_i;
      cnt     <= cnt_nxt;
      if (rise_w) armed <= 1'b1;
      if (done_o && fmt_i == FMT_DSP) dsp_slot <= ~dsp_slot;
    end
  end

endmodule

// File: rtl/ar_words.sv
module ar_words #(
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_rise_i,
  input  logic             din_i,
  input  logic [4:0]       nbits_i,
  input  logic             done_i,
  input  logic             left_i,
  input  logic             take_prev_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);

  localparam int SH_W = $clog2(OUT_W + 1);

  logic [OUT_W-1:0] sr, shifted, word, aligned, lbuf;
  logic [SH_W-1:0]  shamt;
  logic             have_left;

  always_comb begin
    shifted = {sr[OUT_W-2:0], din_i};
    word    = take_prev_i ? sr : shifted;
    shamt   = SH_W'(OUT_W) - SH_W'(nbits_i);
    aligned = word << shamt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr        <= '0;
      lbuf      <= '0;
      have_left <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_rise_i) sr <= shifted;
      if (done_i) begin
        if (left_i) begin
          lbuf      <= aligned;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o    <= lbuf;
          right_o   <= aligned;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/ar_rx.sv
module ar_rx
  import ar_pkg::*;
#(
  parameter int OUT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_i,
  input  logic             lrck_i,
  input  logic             sdata_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       wsel_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);

  logic [2:0] sync_q;
  logic       bclk_s, lr_s, din_s, bclk_d, bit_rise;
  logic       done, chan_left, take_prev;
  logic [4:0] nbits;
  fmt_e       fmt;

  ar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({bclk_i, lrck_i, sdata_i}),
    .q_o (sync_q)
  );

  assign {bclk_s, lr_s, din_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) bclk_d <= 1'b0;
    else     bclk_d <= bclk_s;
  end

  assign bit_rise = bclk_s & ~bclk_d;
  assign nbits    = word_bits(wsel_i);
  assign fmt      = fmt_e'(fmt_i);

  ar_framer #(.CNT_W(CNT_W)) u_framer (
    .clk         (clk),
    .rst         (rst),
    .bit_rise_i  (bit_rise),
    .lr_i        (lr_s),
    .fmt_i       (fmt),
    .nbits_i     (nbits),
    .done_o      (done),
    .left_o      (chan_left),
    .take_prev_o (take_prev)
  );

  ar_words #(.OUT_W(OUT_W)) u_words (
    .clk         (clk),
    .rst         (rst),
    .bit_rise_i  (bit_rise),
    .din_i       (din_s),
    .nbits_i     (nbits),
    .done_i      (done),
    .left_i      (chan_left),
    .take_prev_i (take_prev),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o)
  );

endmodule

// File: rtl/ar_rx_checker.sv
module ar_rx_checker #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_rise,
  input logic             lr_s,
  input logic [1:0]       wsel,
  input logic [OUT_W-1:0] left,
  input logic [OUT_W-1:0] right,
  input logic             valid
);

  logic lr_seen, seen_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_seen   <= 1'b0;
      seen_rise <= 1'b0;
    end else if (bit_rise) begin
      lr_seen <= lr_s;
      if (lr_s && !lr_seen) seen_rise <= 1'b1;
    end
  end

  // R1: no pair is reported before a rising frame edge has been seen
  assert_armed_R1: assert property (@(posedge clk) disable iff (rst)
    valid |-> seen_rise);

  // R7: strobe lasts a single cycle
  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R7: outputs hold between strobes
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(left) && $stable(right)));

  // R6: 20- and 16-bit words are zero padded below the LSB
  assert_pad20_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && wsel != 2'd0) |-> (left[3:0] == 4'd0 && right[3:0] == 4'd0));

  assert_pad16_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && wsel[1]) |-> (left[7:0] == 8'd0 && right[7:0] == 8'd0));

endmodule

bind ar_rx ar_rx_checker #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_rise (bit_rise),
  .lr_s     (lr_s),
  .wsel     (wsel_i),
  .left     (left_o),
  .right    (right_o),
  .valid    (valid_o)
);

// File: tb/tb_ar_rx.sv
`timescale 1ns/1ps
module tb_ar_rx;

  localparam int K = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic [1:0]  fmt = 2'd0, wsel = 2'd0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int errors = 0;
  int checks = 0;
  int got_n = 0;
  logic [23:0] got_l [0:63];
  logic [23:0] got_r [0:63];

  always #2.5 clk = ~clk;

  ar_rx dut (
    .clk(clk), .rst(rst), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_i(fmt), .wsel_i(wsel), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (!rst && valid_o && got_n < 64) begin
      got_l[got_n] = left_o;
      got_r[got_n] = right_o;
      got_n = got_n + 1;
    end
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] w);
    return (w == 2'd0) ? 24 : (w == 2'd1) ? 20 : 16;
  endfunction

  // Raw n-bit sample value for frame i.
  function automatic logic [23:0] sample(input int i, input int salt, input int n);
    logic [23:0] mask;
    logic [31:0] h;
    mask = 24'((32'd1 << n) - 1);
    if (i == 0) return 24'(32'd1 << (n - 1));
    if (i == 1) return mask;
    h = (32'(i + salt) * 32'h9E3779B1) ^ (32'(i) * 32'h00005A5A);
    return h[23:0] & mask;
  endfunction

  task automatic do_reset(input logic [1:0] f, input logic [1:0] w);
    rst = 1'b1; bclk = 1'b0; lrck = 1'b0; sdata = 1'b0;
    fmt = f; wsel = w;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", {23'd0, valid_o}, 24'd0);
    check("R1 reset left", left_o, 24'd0);
    check("R1 reset right", right_o, 24'd0);
    got_n = 0;
    @(posedge clk);
    rst = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  // One stereo frame of 64 bit clocks; unused slots carry ones.
  task automatic send_frame(input logic [1:0] f, input int n,
                            input logic [23:0] lv, input logic [23:0] rv, input int gap);
    for (int p = 0; p < 64; p++) begin
      logic lr, d;
      d = 1'b1;
      case (f)
        2'd0: begin
          lr = (p >= 32);
          if (p >= 1 && p <= n) d = lv[n - p];
          if (p >= 33 && p <= 32 + n) d = rv[n - (p - 32)];
        end
        2'd1: begin
          lr = (p < 32);
          if (p < n) d = lv[n - 1 - p];
          if (p >= 32 && p < 32 + n) d = rv[n - 1 - (p - 32)];
        end
        2'd2: begin
          lr = (p < 32);
          if (p >= 32 - n && p < 32) d = lv[31 - p];
          if (p >= 64 - n) d = rv[63 - p];
        end
        default: begin
          lr = (p == 0 || p == 32);
          if (p >= 1 && p <= n) d = lv[n - p];
          if (p >= 33 && p <= 32 + n) d = rv[n - (p - 32)];
        end
      endcase
      bclk = 1'b0; lrck = lr; sdata = d;
      repeat (4 + (gap ? (p % 4) * 5 : 0)) @(posedge clk);
      bclk = 1'b1;
      repeat (4) @(posedge clk);
    end
  endtask

  task automatic run_case(input string tag, input logic [1:0] f, input logic [1:0] w,
                          input int gap);
    int n, first, exp_n, salt;
    n = nbits_of(w);
    salt = 11 * int'(f) + 3 * int'(w) + gap;
    do_reset(f, w);
    for (int i = 0; i < K; i++)
      send_frame(f, n, sample(i, salt, n), sample(i, salt + 7, n), gap);
    if (f == 2'd2) send_frame(f, n, 24'd0, 24'd0, gap);
    bclk = 1'b0;
    repeat (40) @(posedge clk);
    first = (f == 2'd0) ? 1 : 0;
    exp_n = K - first;
    check((f == 2'd0) ? {tag, " R1 R7 pair count"} : {tag, " R7 pair count"},
          24'(got_n), 24'(exp_n));
    for (int j = 0; j < exp_n && j < got_n; j++) begin
      logic [23:0] el, er;
      el = sample(first + j, salt, n) << (24 - n);
      er = sample(first + j, salt + 7, n) << (24 - n);
      check({tag, " left"}, got_l[j], el);
      check({tag, " right"}, got_r[j], er);
      if (n < 24) check({tag, " R6 zero pad"},
                        got_l[j] & 24'((32'd1 << (24 - n)) - 1), 24'd0);
    end
  endtask

  initial begin
    run_case("R2 i2s 24", 2'd0, 2'd0, 0);
    run_case("R2 R6 i2s 16", 2'd0, 2'd2, 0);
    run_case("R3 R6 lj 20", 2'd1, 2'd1, 0);
    run_case("R3 lj 24", 2'd1, 2'd0, 0);
    run_case("R4 R6 rj 16", 2'd2, 2'd2, 0);
    run_case("R4 rj 24", 2'd2, 2'd0, 0);
    run_case("R5 dsp 24", 2'd3, 2'd0, 0);
    run_case("R5 R6 dsp 20", 2'd3, 2'd1, 0);
    run_case("R6 lj code3 16", 2'd1, 2'd3, 0);
    run_case("R8 rj 20 gaps", 2'd2, 2'd1, 1);
    run_case("R8 i2s 24 gaps", 2'd0, 2'd0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule